// File: doc/BRIEF.md
# Block-Gated Memory Security Controller

This block guards one protected memory. The memory is cut into equal blocks whose size is a power of two, and a lookup table holds one bit per block that says whether non-secure transfers may touch it. Software programs the table and the controller's settings through a small word-addressed register bus with a ready that is always high. The table is not mapped directly: an index register picks a 32-bit table word, a data register reads or writes that word, and the index can step forward by itself after each data access so that the whole table can be streamed.

A second port presents each incoming transfer's byte address, security attribute and direction. In the same cycle the block either lets the transfer through or marks it as a violation, answered with an error response or masked as read-as-zero/write-ignored, depending on a control bit. The first violation records its address and attributes and raises a status bit, which drives an interrupt when enabled. A sticky lock bit, cleared only by reset, freezes the table and the security settings once software has finished configuring.

Top module: `memgate_ctrl`

## Requirements
- R1: After reset the control word, the index, the interrupt status, the interrupt enable and every table word read as 0, so all blocks start secure-only and `irq` is low.
- R2: Word 4 reads LUT_WORDS-1 (highest table word index) and word 5 reads BLK_CFG; writes to both are ignored.
- R3: A block's number is the transfer byte address shifted right by BLK_CFG+5; bit n of table word i covers block i*32+n, where 1 allows non-secure transfers and 0 allows secure transfers only.
- R4: A transfer is a violation when its attribute (`xfer_nonsec`, 1 = non-secure) differs from its block's bit, or when its block number is LUT_WORDS*32 or more; `xfer_ok` is high in the same cycle only for a valid transfer that is not a violation.
- R5: Control bit 4 picks the answer to a violation in the same cycle: 1 raises `xfer_berr`, 0 raises `xfer_raz`; never both.
- R6: With control bit 8 set, each read or write of the table data register (word 7) advances the index (word 6) by one after the access, wrapping from LUT_WORDS-1 to 0; with bit 8 clear the index holds.
- R7: Control bit 31 is a lock that stays set until reset; while it is set, writes to the table data register do not change the table and writes to control bits 4 and 31 are ignored, while bit 8 and the index stay writable.
- R8: A violation while the status bit (word 8 bit 0) is clear sets it on the next edge and records the byte address in word 11 and, in word 12, the attribute in bit 0 and the direction (1 = write) in bit 1; while status is set both stay unchanged.
- R9: `irq` equals status bit 0 AND enable bit 0 (word 10); writing 1 in bit 0 of word 9 clears status, writing 1 in bit 0 of word 13 sets it, and a same-cycle violation or set wins over clear.
- R10: Reserved words (1 to 3, 14, 15) and the write-only words 9 and 13 read as 0, and `pready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register bus select |
| penable | input | 1 | Register bus access phase |
| pwrite | input | 1 | Register bus write (1) or read (0) |
| paddr | input | REG_AW | Register word address |
| pwdata | input | 32 | Register write data |
| prdata | output | 32 | Register read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| xfer_valid | input | 1 | A transfer to the protected memory is presented |
| xfer_addr | input | ADDR_W | Transfer byte address within the protected memory |
| xfer_nonsec | input | 1 | Transfer attribute, 1 = non-secure |
| xfer_write | input | 1 | Transfer direction, 1 = write |
| xfer_ok | output | 1 | Transfer permitted |
| xfer_berr | output | 1 | Violation answered with an error response |
| xfer_raz | output | 1 | Violation masked as read-as-zero/write-ignored |
| irq | output | 1 | Interrupt, status gated by enable |

## Verification
The transfer verdicts `xfer_ok`, `xfer_berr` and `xfer_raz` are combinational and are compared in the same cycle the transfer is presented, at the falling edge. Register read data is due in the access phase of a bus read and is compared at that phase's falling edge, while register writes, index stepping, fault capture and status changes land on the rising edge that closes the access or transfer cycle, so every check that depends on them is issued as a later bus read or sampled on `irq` after that edge. A scoreboard queue holds each expected value in the order the accesses are issued, and a monitor pops the head at the matching falling edge.

// File: rtl/memgate_pkg.sv
package memgate_pkg;

  // register word offsets
  localparam int OFS_CTRL   = 0;
  localparam int OFS_MAXIDX = 4;
  localparam int OFS_BLKCFG = 5;
  localparam int OFS_INDEX  = 6;
  localparam int OFS_DATA   = 7;
  localparam int OFS_STAT   = 8;
  localparam int OFS_CLR    = 9;
  localparam int OFS_EN     = 10;
  localparam int OFS_FADDR  = 11;
  localparam int OFS_FATTR  = 12;
  localparam int OFS_SET    = 13;

  // control bit positions
  localparam int CTL_RESP = 4;
  localparam int CTL_STEP = 8;
  localparam int CTL_LOCK = 31;

  localparam int BLK_BASE_SHIFT = 5;

  // block number covering a byte address
  function automatic logic [31:0] block_number(input logic [31:0] addr,
                                               input int unsigned cfg);
    return addr >> (cfg + BLK_BASE_SHIFT);
  endfunction

  // next table index with wrap at the last word
  function automatic int unsigned next_index(input int unsigned cur,
                                             input int unsigned words);
    return (cur == words - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/memgate_lut.sv
module memgate_lut #(
  parameter int LUT_WORDS = 4,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_data,
  input  logic [IDX_W-1:0] chk_word,
  input  logic [4:0]       chk_bit,
  output logic             chk_allow_ns
);

  logic [31:0] words [LUT_WORDS];

  for (genvar g = 0; g < LUT_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        words[g] <= wr_data;
    end
  end

  assign rd_data      = words[rd_idx];
  assign chk_allow_ns = words[chk_word][chk_bit];

endmodule

// File: rtl/memgate_regs.sv
module memgate_regs
  import memgate_pkg::*;
#(
  parameter int LUT_WORDS = 4,
  parameter int BLK_CFG   = 3,
  parameter int REG_AW    = 4,
  parameter int IDX_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [REG_AW-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [31:0]       lut_rd_data,
  input  logic              stat,
  input  logic              int_en_q,
  input  logic [31:0]       fault_addr,
  input  logic [1:0]        fault_attr,
  output logic              resp_berr,
  output logic              step_en,
  output logic              locked,
  output logic [IDX_W-1:0]  index,
  output logic              data_access,
  output logic              lut_wr_en,
  output logic              en_wr,
  output logic              clr_pulse,
  output logic              set_pulse
);

  logic acc, wr_acc;
  assign acc    = psel && penable;
  assign wr_acc = acc && pwrite;

  function automatic logic hit(input logic [REG_AW-1:0] a, input int ofs);
    return a == REG_AW'(ofs);
  endfunction

  assign data_access = acc && hit(paddr, OFS_DATA);
  assign lut_wr_en   = wr_acc && hit(paddr, OFS_DATA) && !locked;
  assign en_wr       = wr_acc && hit(paddr, OFS_EN);
  assign clr_pulse   = wr_acc && hit(paddr, OFS_CLR) && pwdata[0];
  assign set_pulse   = wr_acc && hit(paddr, OFS_SET) && pwdata[0];

  // control word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_berr <= 1'b0;
      step_en   <= 1'b0;
      locked    <= 1'b0;
    end else if (wr_acc && hit(paddr, OFS_CTRL)) begin
      step_en <= pwdata[CTL_STEP];
      if (!locked) begin
        resp_berr <= pwdata[CTL_RESP];
        locked    <= pwdata[CTL_LOCK];
      end
    end
  end

  // table index with optional stepping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      index <= '0;
    else if (wr_acc && hit(paddr, OFS_INDEX))
      index <= pwdata[IDX_W-1:0];
    else if (data_access && step_en)
      index <= IDX_W'(next_index(int'(index), LUT_WORDS));
  end

  always_comb begin
    prdata = '0;
    if (psel) begin
      case (paddr)
        REG_AW'(OFS_CTRL): begin
          prdata[CTL_RESP] = resp_berr;
          prdata[CTL_STEP] = step_en;
          prdata[CTL_LOCK] = locked;
        end
        REG_AW'(OFS_MAXIDX): prdata = 32'(LUT_WORDS - 1);
        REG_AW'(OFS_BLKCFG): prdata = 32'(BLK_CFG);
        REG_AW'(OFS_INDEX):  prdata = 32'(index);
        REG_AW'(OFS_DATA):   prdata = lut_rd_data;
        REG_AW'(OFS_STAT):   prdata = {31'b0, stat};
        REG_AW'(OFS_EN):     prdata = {31'b0, int_en_q};
        REG_AW'(OFS_FADDR):  prdata = fault_addr;
        REG_AW'(OFS_FATTR):  prdata = {30'b0, fault_attr};
        default:             prdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/memgate_fault.sv
module memgate_fault (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        viol,
  input  logic [31:0] viol_addr,
  input  logic        viol_nonsec,
  input  logic        viol_write,
  input  logic        clr_pulse,
  input  logic        set_pulse,
  input  logic        en_wr,
  input  logic        en_data,
  output logic        stat,
  output logic        int_en_q,
  output logic [31:0] fault_addr,
  output logic [1:0]  fault_attr,
  output logic        capture
);

  assign capture = viol && !stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stat <= 1'b0;
    else if (viol || set_pulse)
      stat <= 1'b1;
    else if (clr_pulse)
      stat <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_addr <= '0;
      fault_attr <= '0;
    end else if (capture) begin
      fault_addr <= viol_addr;
      fault_attr <= {viol_write, viol_nonsec};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      int_en_q <= 1'b0;
    else if (en_wr)
      int_en_q <= en_data;
  end

endmodule

// File: rtl/memgate_ctrl.sv
module memgate_ctrl
  import memgate_pkg::*;
#(
  parameter int LUT_WORDS = 4,
  parameter int BLK_CFG   = 3,
  parameter int REG_AW    = 4,
  parameter int ADDR_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [REG_AW-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic              xfer_valid,
  input  logic [ADDR_W-1:0] xfer_addr,
  input  logic              xfer_nonsec,
  input  logic              xfer_write,
  output logic              xfer_ok,
  output logic              xfer_berr,
  output logic              xfer_raz,
  output logic              irq
);

  localparam int IDX_W      = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1;
  localparam int NUM_BLOCKS = LUT_WORDS * 32;

  logic             resp_berr, step_en, locked;
  logic [IDX_W-1:0] index;
  logic             data_access, lut_wr_en, en_wr, clr_pulse, set_pulse;
  logic [31:0]      lut_rd_data;
  logic             stat, int_en_q, capture;
  logic [31:0]      fault_addr;
  logic [1:0]       fault_attr;

  // transfer decode
  logic [31:0]      addr32, blk;
  logic             in_range, allow_ns, viol;
  logic [IDX_W-1:0] chk_word;

  assign addr32   = 32'(xfer_addr);
  assign blk      = block_number(addr32, BLK_CFG);
  assign in_range = blk < 32'(NUM_BLOCKS);
  assign chk_word = blk[5 +: IDX_W];

  memgate_regs #(
    .LUT_WORDS(LUT_WORDS), .BLK_CFG(BLK_CFG), .REG_AW(REG_AW), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .lut_rd_data(lut_rd_data), .stat(stat), .int_en_q(int_en_q),
    .fault_addr(fault_addr), .fault_attr(fault_attr),
    .resp_berr(resp_berr), .step_en(step_en), .locked(locked), .index(index),
    .data_access(data_access), .lut_wr_en(lut_wr_en), .en_wr(en_wr),
    .clr_pulse(clr_pulse), .set_pulse(set_pulse)
  );

  memgate_lut #(.LUT_WORDS(LUT_WORDS), .IDX_W(IDX_W)) u_lut (
    .clk(clk), .rst_n(rst_n), .wr_en(lut_wr_en), .wr_idx(index),
    .wr_data(pwdata), .rd_idx(index), .rd_data(lut_rd_data),
    .chk_word(chk_word), .chk_bit(blk[4:0]), .chk_allow_ns(allow_ns)
  );

  assign viol      = xfer_valid && (!in_range || (allow_ns != xfer_nonsec));
  assign xfer_ok   = xfer_valid && !viol;
  assign xfer_berr = viol && resp_berr;
  assign xfer_raz  = viol && !resp_berr;

  memgate_fault u_fault (
    .clk(clk), .rst_n(rst_n), .viol(viol), .viol_addr(addr32),
    .viol_nonsec(xfer_nonsec), .viol_write(xfer_write),
    .clr_pulse(clr_pulse), .set_pulse(set_pulse),
    .en_wr(en_wr), .en_data(pwdata[0]),
    .stat(stat), .int_en_q(int_en_q), .fault_addr(fault_addr),
    .fault_attr(fault_attr), .capture(capture)
  );

  assign irq    = stat && int_en_q;
  assign pready = 1'b1;

endmodule

// File: rtl/memgate_ctrl_sva.sv
module memgate_ctrl_sva #(
  parameter int LUT_WORDS = 4,
  parameter int IDX_W     = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pready,
  input logic             xfer_valid,
  input logic             xfer_ok,
  input logic             xfer_berr,
  input logic             xfer_raz,
  input logic             irq,
  input logic             locked,
  input logic             step_en,
  input logic [IDX_W-1:0] index,
  input logic             data_access,
  input logic             lut_wr_en,
  input logic             stat,
  input logic             int_en_q,
  input logic [31:0]      fault_addr
);

  p_ready_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pready);

  p_single_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({xfer_ok, xfer_berr, xfer_raz}) <= 1);

  p_verdict_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_valid |-> !(xfer_ok || xfer_berr || xfer_raz));

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  p_no_table_write_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !lut_wr_en);

  p_index_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_access && step_en |=>
      index == (($past(index) == IDX_W'(LUT_WORDS - 1)) ? '0 : $past(index) + 1'b1));

  p_fault_sets_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_berr || xfer_raz) |=> stat);

  p_info_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat |=> $stable(fault_addr));

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en_q |-> !irq);

endmodule

bind memgate_ctrl memgate_ctrl_sva #(.LUT_WORDS(LUT_WORDS), .IDX_W(IDX_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .pready(pready), .xfer_valid(xfer_valid),
  .xfer_ok(xfer_ok), .xfer_berr(xfer_berr), .xfer_raz(xfer_raz), .irq(irq),
  .locked(locked), .step_en(step_en), .index(index),
  .data_access(data_access), .lut_wr_en(lut_wr_en), .stat(stat),
  .int_en_q(int_en_q), .fault_addr(fault_addr)
);

// File: tb/tb_memgate_ctrl.sv
`timescale 1ns/1ps
module tb_memgate_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        xfer_valid = 1'b0, xfer_nonsec = 1'b0, xfer_write = 1'b0;
  logic [31:0] xfer_addr = '0;
  logic        xfer_ok, xfer_berr, xfer_raz, irq;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // scoreboard: kind 0 = register read, kind 1 = transfer verdict {ok,berr,raz}
  int          q_kind[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  memgate_ctrl dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_nonsec(xfer_nonsec),
    .xfer_write(xfer_write), .xfer_ok(xfer_ok), .xfer_berr(xfer_berr),
    .xfer_raz(xfer_raz), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (psel && penable && !pwrite) begin
      if (q_kind.size() == 0 || q_kind[0] != 0) chk("scoreboard order (read)", 32'd1, 32'd0);
      else begin
        void'(q_kind.pop_front());
        chk(q_tag.pop_front(), prdata, q_exp.pop_front());
      end
    end
    if (xfer_valid) begin
      if (q_kind.size() == 0 || q_kind[0] != 1) chk("scoreboard order (xfer)", 32'd1, 32'd0);
      else begin
        void'(q_kind.pop_front());
        chk(q_tag.pop_front(), {29'b0, xfer_ok, xfer_berr, xfer_raz}, q_exp.pop_front());
      end
    end
  end

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    psel = 1; pwrite = 1; penable = 0; paddr = 4'(a); pwdata = d;
    @(posedge clk); #1; penable = 1;
    @(posedge clk); #1; psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input int a, input logic [31:0] e, input string tag);
    q_kind.push_back(0); q_exp.push_back(e); q_tag.push_back(tag);
    @(posedge clk); #1;
    psel = 1; pwrite = 0; penable = 0; paddr = 4'(a);
    @(posedge clk); #1; penable = 1;
    @(posedge clk); #1; psel = 0; penable = 0;
  endtask

  // exp: 4 = ok, 2 = error response, 1 = read-as-zero/write-ignored
  task automatic xfer(input logic [31:0] a, input logic ns, input logic wr,
                      input logic [31:0] e, input string tag);
    q_kind.push_back(1); q_exp.push_back(e); q_tag.push_back(tag);
    @(posedge clk); #1;
    xfer_valid = 1; xfer_addr = a; xfer_nonsec = ns; xfer_write = wr;
    @(posedge clk); #1; xfer_valid = 0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    chk(tag, {31'b0, irq}, {31'b0, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    bus_rd(0, 32'h0, "R1 control after reset");
    bus_rd(6, 32'h0, "R1 index after reset");
    bus_rd(7, 32'h0, "R1 table word 0 after reset");
    bus_rd(8, 32'h0, "R1 status after reset");
    bus_rd(10, 32'h0, "R1 enable after reset");
    chk_irq(1'b0, "R1 irq after reset");

    // R2 read-only geometry words
    bus_rd(4, 32'd3, "R2 max index");
    bus_rd(5, 32'd3, "R2 block config");
    bus_wr(4, 32'hFF);
    bus_wr(5, 32'hFF);
    bus_rd(4, 32'd3, "R2 max index after write");
    bus_rd(5, 32'd3, "R2 block config after write");

    // R10 reserved and write-only words
    bus_rd(1, 32'h0, "R10 reserved word 1");
    bus_rd(9, 32'h0, "R10 clear word reads 0");
    bus_rd(13, 32'h0, "R10 set word reads 0");
    chk("R10 pready", {31'b0, pready}, 32'd1);

    // R3/R4/R5 secure-only table
    xfer(32'h100, 0, 0, 32'd4, "R3 secure to secure block");
    xfer(32'h100, 1, 0, 32'd1, "R5 non-secure masked");
    bus_rd(8, 32'd1, "R8 status set");
    bus_rd(11, 32'h100, "R8 fault address");
    bus_rd(12, 32'd1, "R8 fault attributes");
    chk_irq(1'b0, "R9 irq masked");
    bus_wr(10, 32'd1);
    chk_irq(1'b1, "R9 irq enabled");
    xfer(32'h200, 1, 1, 32'd1, "R4 second violation");
    bus_rd(11, 32'h100, "R8 address held");
    bus_rd(12, 32'd1, "R8 attributes held");
    bus_wr(9, 32'd1);
    bus_rd(8, 32'd0, "R9 status cleared");
    chk_irq(1'b0, "R9 irq after clear");

    // R3 programmed word 2: blocks 68..71 non-secure
    bus_wr(6, 32'd2);
    bus_wr(7, 32'h0000_00F0);
    bus_rd(7, 32'h0000_00F0, "R3 table readback");
    bus_rd(6, 32'd2, "R6 index holds with stepping off");
    xfer(32'h4400, 1, 0, 32'd4, "R3 non-secure block 68");
    xfer(32'h4300, 1, 0, 32'd1, "R3 block 67 secure only");
    bus_rd(11, 32'h4300, "R8 fault address block 67");
    bus_wr(9, 32'd1);
    bus_wr(0, 32'h10);
    xfer(32'h4400, 0, 1, 32'd2, "R5 secure write to non-secure block errors");
    bus_rd(11, 32'h4400, "R8 fault address write");
    bus_rd(12, 32'd2, "R8 write direction recorded");
    bus_wr(9, 32'd1);

    // R4 beyond the table
    xfer(32'h8000, 1, 0, 32'd2, "R4 out of range non-secure");
    xfer(32'h8000, 0, 0, 32'd2, "R4 out of range secure");
    bus_wr(9, 32'd1);

    // R6 stepping index with wrap
    bus_wr(0, 32'h110);
    bus_wr(6, 32'd3);
    bus_wr(7, 32'hAAAA_0000);
    bus_wr(7, 32'h0000_0005);
    bus_rd(6, 32'd1, "R6 index wrapped and stepped");
    bus_rd(7, 32'h0, "R6 stream word 1");
    bus_rd(7, 32'h0000_00F0, "R6 stream word 2");
    bus_rd(7, 32'hAAAA_0000, "R6 stream word 3");
    bus_rd(7, 32'h0000_0005, "R6 stream word 0");
    bus_rd(6, 32'd1, "R6 index after stream");
    bus_wr(0, 32'h10);
    bus_rd(7, 32'h0, "R6 read with stepping off");
    bus_rd(6, 32'd1, "R6 index held");
    xfer(32'h000, 1, 0, 32'd4, "R3 block 0 non-secure");
    xfer(32'h100, 1, 0, 32'd2, "R3 block 1 secure only");
    xfer(32'h200, 1, 0, 32'd4, "R3 block 2 non-secure");
    bus_wr(9, 32'd1);

    // R9 debug set
    bus_wr(13, 32'd1);
    bus_rd(8, 32'd1, "R9 status forced");
    chk_irq(1'b1, "R9 irq from forced status");
    bus_wr(9, 32'd1);
    bus_rd(8, 32'd0, "R9 forced status cleared");

    // R7 lock
    bus_wr(0, 32'h8000_0010);
    bus_rd(0, 32'h8000_0010, "R7 lock set");
    bus_wr(6, 32'd0);
    bus_wr(7, 32'hFFFF_FFFF);
    bus_rd(7, 32'h0000_0005, "R7 table frozen");
    bus_wr(0, 32'h100);
    bus_rd(0, 32'h8000_0110, "R7 security bits frozen, step writable");
    xfer(32'h100, 1, 0, 32'd2, "R7 locked response kept");

    repeat (3) @(posedge clk);
    chk("scoreboard drained", 32'(q_kind.size()), 32'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule